// File: doc/BRIEF.md
# Bursting Memory-Mapped Request Master

This block turns request descriptors, taken one at a time from an upstream queue, into bursts on a memory-mapped master port with a 512-bit data bus. Each descriptor says whether the request reads or writes and which function, virtual function and BAR it targets. It also carries a dword-aligned byte offset, a length in dwords, the byte enables of the first and last dword, and a tag. The block forms the byte address from these fields. It splits the request into bursts of at most 15 beats and works out a byte-enable mask for every beat. Write data comes from a separate stream, one bus word per accepted write beat.

The slave may raise waitrequest, and the master keeps issuing for a bounded number of transfers before it stops. Read bursts that have been issued are remembered in order. Each returning read-data beat is passed straight through with the tag of its request, and a last flag marks the final beat of each burst.

Top module: `bmm_req_master`

## Requirements
- R1: The address presented is, from most to least significant bit, the virtual-function-active flag (1 bit), the physical-function index (2 bits), the virtual-function number (11 bits), the BAR number (3 bits) and a 22-bit offset (39 bits in all).
- R2: The six low address bits are always zero, so every address is aligned to the 64-byte bus width. A burst's address is the 64-byte line that holds its first beat.
- R3: For writes and single-beat reads, byte-enable bit j covers data byte j. A bit is high only when its byte lies within the request, which starts at offset with bits 1:0 cleared and spans 4×length bytes. Within the first dword of the request, byte k is enabled by first-BE bit k. Within the last dword, byte k is enabled by last-BE bit k. A one-dword request uses only the first BE.
- R4: A read burst with a burst count above 1 drives all 64 byte-enable bits high, whatever the first and last BE fields hold.
- R5: A request occupies as many beats as the 64-byte lines its bytes touch. It is issued as bursts of min(remaining, 15) beats. Each later burst's address is 64 × (earlier count) above the one before it. The burst count is never 0.
- R6: Within a write burst, the address and burst count stay the same on every beat. Write-data ready is high exactly in the cycles where a write is issued, and each issued beat carries the current write-data word.
- R7: A credit of 16 is reloaded at every clock edge where waitrequest is low. Each transfer issued while waitrequest is high uses one credit. With no credit left, nothing is issued until waitrequest has been low at an edge.
- R8: The read and write strobes are never high in the same cycle.
- R9: Each read-data-valid beat appears on the response outputs in the same cycle, with its data and the tag of the oldest read burst still open. The last flag is high on the n-th beat returned for a burst of count n and low on the others.
- R10: After reset the block is idle: descriptor-ready is high and the read, write and response strobes are low. While a descriptor is still being issued, descriptor-ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Descriptor offered |
| req_ready_o | output | 1 | Descriptor taken (block idle) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_vf_active_i | input | 1 | Virtual function active flag |
| req_pf_i | input | 2 | Physical function index |
| req_vf_i | input | 11 | Virtual function number |
| req_bar_i | input | 3 | BAR number |
| req_offset_i | input | 22 | Byte offset in the BAR (bits 1:0 ignored) |
| req_len_i | input | 11 | Length in dwords, nonzero |
| req_fbe_i | input | 4 | First-dword byte enables |
| req_lbe_i | input | 4 | Last-dword byte enables |
| req_tag_i | input | 8 | Tag returned with read data |
| wd_valid_i | input | 1 | Write data word available |
| wd_data_i | input | 512 | Write data word |
| wd_ready_o | output | 1 | Write data word consumed |
| mm_address_o | output | 39 | Byte address of burst |
| mm_byteenable_o | output | 64 | Byte enables of current beat |
| mm_burstcount_o | output | 4 | Beats in the current burst |
| mm_read_o | output | 1 | Read burst request |
| mm_write_o | output | 1 | Write beat |
| mm_writedata_o | output | 512 | Write beat data |
| mm_readdata_i | input | 512 | Returned read data |
| mm_readdatavalid_i | input | 1 | Returned read data valid |
| mm_waitrequest_i | input | 1 | Slave back-pressure |
| rsp_valid_o | output | 1 | Forwarded read beat valid |
| rsp_data_o | output | 512 | Forwarded read data |
| rsp_tag_o | output | 8 | Tag of the burst being returned |
| rsp_last_o | output | 1 | Final beat of a burst |

## Verification
The test cases use these request shapes:
- A one-dword read at a misaligned offset with non-default IDs. It separates the address field order and the first-BE masking from a plain pass-through of the offset.
- A three-line read. It shows that multi-beat reads ignore the BE fields, and checks that the last flag falls on the third beat only.
- A 16-line read. It must split into bursts of 15 and 1 beats, showing both the burst length limit and the address step.
- A two-beat write that crosses a line. It checks first-BE and last-BE masking on different beats while the address stays the same.
- A 20-beat write started with waitrequest already high. It must issue exactly 16 beats and then stall, which separates correct credit use from never stopping or stopping at once.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
   typedef enum logic {
      DIR_READ  = 1'b0,
      DIR_WRITE = 1'b1
   } bmm_dir_e;

   // dword size in bytes, used for dword-granular offsets
   localparam int unsigned DW_BYTES = 4;
endpackage

// File: rtl/bmm_be_gen.sv
module bmm_be_gen #(
   parameter int unsigned BE_W  = 64,
   parameter int unsigned POS_W = 23,
   localparam int unsigned LSB  = $clog2(BE_W)
)(
   input  logic [POS_W-LSB-1:0] line_i,
   input  logic [POS_W-1:0]     first_i,
   input  logic [POS_W-1:0]     final_i,
   input  logic [3:0]           fbe_i,
   input  logic [3:0]           lbe_i,
   input  logic                 all_i,
   output logic [BE_W-1:0]      be_o
);
   for (genvar j = 0; j < BE_W; j++) begin : g_byte
      logic [POS_W-1:0] pos;
      logic             in_rng, is_first, is_final, msk;
      always_comb begin
         pos      = {line_i, LSB'(j)};
         in_rng   = (pos >= first_i) && (pos <= final_i);
         is_first = pos[POS_W-1:2] == first_i[POS_W-1:2];
         is_final = pos[POS_W-1:2] == final_i[POS_W-1:2];
         msk      = is_first ? fbe_i[j%4] : (is_final ? lbe_i[j%4] : 1'b1);
         be_o[j]  = all_i | (in_rng & msk);
      end
   end
endmodule

// File: rtl/bmm_credit.sv
module bmm_credit #(
   parameter int unsigned ALLOW = 16,
   localparam int unsigned CW   = $clog2(ALLOW + 1)
)(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wait_i,
   input  logic fire_i,
   output logic ok_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     cnt_q <= CW'(ALLOW);
      else if (!wait_i) cnt_q <= CW'(ALLOW);
      else if (fire_i)  cnt_q <= cnt_q - CW'(1);
   end

   assign ok_o = cnt_q != '0;
endmodule

// File: rtl/bmm_rsp_track.sv
module bmm_rsp_track #(
   parameter int unsigned DATA_W = 512,
   parameter int unsigned TAG_W  = 8,
   parameter int unsigned BC_W   = 4,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned AW    = $clog2(DEPTH)
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              push_i,
   input  logic [TAG_W-1:0]  push_tag_i,
   input  logic [BC_W-1:0]   push_cnt_i,
   output logic              room_o,
   input  logic              rdv_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              rsp_valid_o,
   output logic [DATA_W-1:0] rsp_data_o,
   output logic [TAG_W-1:0]  rsp_tag_o,
   output logic              rsp_last_o
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("bmm_rsp_track: DEPTH must be a power of two >= 2");
   end

   logic [TAG_W-1:0] tag_mem [DEPTH];
   logic [BC_W-1:0]  cnt_mem [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [AW:0]      fill_q;
   logic [BC_W-1:0]  beat_q;
   logic             done;

   assign room_o      = fill_q != (AW+1)'(DEPTH);
   assign done        = rdv_i && ((beat_q + BC_W'(1)) == cnt_mem[rp_q]);
   assign rsp_valid_o = rdv_i;
   assign rsp_data_o  = rdata_i;
   assign rsp_tag_o   = tag_mem[rp_q];
   assign rsp_last_o  = done;

   always_ff @(posedge clk_i) begin
      if (push_i) begin
         tag_mem[wp_q] <= push_tag_i;
         cnt_mem[wp_q] <= push_cnt_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         wp_q   <= '0;
         rp_q   <= '0;
         fill_q <= '0;
         beat_q <= '0;
      end else begin
         if (push_i) wp_q <= wp_q + AW'(1);
         if (done)   rp_q <= rp_q + AW'(1);
         fill_q <= fill_q + {{AW{1'b0}}, push_i} - {{AW{1'b0}}, done};
         if (done)       beat_q <= '0;
         else if (rdv_i) beat_q <= beat_q + BC_W'(1);
      end
   end
endmodule

// File: rtl/bmm_req_master.sv
module bmm_req_master #(
   parameter int unsigned DATA_W   = 512,
   parameter int unsigned PF_NUM   = 4,
   parameter int unsigned VF_W     = 11,
   parameter int unsigned BAR_W    = 3,
   parameter int unsigned OFS_W    = 22,
   parameter int unsigned LEN_W    = 11,
   parameter int unsigned TAG_W    = 8,
   parameter int unsigned BC_W     = 4,
   parameter int unsigned ALLOW    = 16,
   parameter int unsigned RD_DEPTH = 8,
   localparam int unsigned PF_W    = (PF_NUM > 1) ? $clog2(PF_NUM) : 1,
   localparam int unsigned BE_W    = DATA_W / 8,
   localparam int unsigned ADDR_W  = 1 + PF_W + VF_W + BAR_W + OFS_W
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic              req_write_i,
   input  logic              req_vf_active_i,
   input  logic [PF_W-1:0]   req_pf_i,
   input  logic [VF_W-1:0]   req_vf_i,
   input  logic [BAR_W-1:0]  req_bar_i,
   input  logic [OFS_W-1:0]  req_offset_i,
   input  logic [LEN_W-1:0]  req_len_i,
   input  logic [3:0]        req_fbe_i,
   input  logic [3:0]        req_lbe_i,
   input  logic [TAG_W-1:0]  req_tag_i,
   input  logic              wd_valid_i,
   input  logic [DATA_W-1:0] wd_data_i,
   output logic              wd_ready_o,
   output logic [ADDR_W-1:0] mm_address_o,
   output logic [BE_W-1:0]   mm_byteenable_o,
   output logic [BC_W-1:0]   mm_burstcount_o,
   output logic              mm_read_o,
   output logic              mm_write_o,
   output logic [DATA_W-1:0] mm_writedata_o,
   input  logic [DATA_W-1:0] mm_readdata_i,
   input  logic              mm_readdatavalid_i,
   input  logic              mm_waitrequest_i,
   output logic              rsp_valid_o,
   output logic [DATA_W-1:0] rsp_data_o,
   output logic [TAG_W-1:0]  rsp_tag_o,
   output logic              rsp_last_o
);
   import bmm_pkg::*;

   localparam int unsigned LSB    = $clog2(BE_W);
   localparam int unsigned POS_W  = OFS_W + 1;
   localparam int unsigned LINE_W = OFS_W - LSB;
   localparam int unsigned TOT_W  = POS_W - LSB;
   localparam int unsigned MAXB   = (1 << BC_W) - 1;

   if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_dw
      $error("bmm_req_master: DATA_W must be a power of two >= 32");
   end
   if (OFS_W <= LSB || LEN_W + 2 > OFS_W) begin : g_bad_ofs
      $error("bmm_req_master: OFS_W too small for bus width or length");
   end
   if (ALLOW < 1 || BC_W < 1) begin : g_bad_cfg
      $error("bmm_req_master: ALLOW and BC_W must be nonzero");
   end

   function automatic logic [BC_W-1:0] clip(input logic [TOT_W-1:0] n);
      return (n > TOT_W'(MAXB)) ? BC_W'(MAXB) : n[BC_W-1:0];
   endfunction

   logic               act_q;
   bmm_dir_e           dir_q;
   logic               vfa_q;
   logic [PF_W-1:0]    pf_q;
   logic [VF_W-1:0]    vf_q;
   logic [BAR_W-1:0]   bar_q;
   logic [LINE_W-1:0]  line_q, aline_q;
   logic [TOT_W-1:0]   left_q;
   logic [BC_W-1:0]    bsz_q, inb_q;
   logic [POS_W-1:0]   sb_q, eb_q;
   logic [3:0]         fbe_q, lbe_q;
   logic [TAG_W-1:0]   tag_q;

   logic [POS_W-1:0]   sb_n, eb_n;
   logic [TOT_W-1:0]   tot_n, step, left_n;
   logic               acc, fire, cred_ok, rd_room, brk;

   always_comb begin
      sb_n   = {1'b0, req_offset_i[OFS_W-1:2], 2'b00};
      eb_n   = sb_n + POS_W'({req_len_i, 2'b00}) - POS_W'(1);
      tot_n  = eb_n[POS_W-1:LSB] - sb_n[POS_W-1:LSB] + TOT_W'(1);
      step   = (dir_q == DIR_WRITE) ? TOT_W'(1) : TOT_W'(bsz_q);
      left_n = left_q - step;
      brk    = (dir_q == DIR_READ) || (inb_q == BC_W'(1));
   end

   assign req_ready_o = !act_q;
   assign acc         = req_valid_i && !act_q;
   assign mm_read_o   = act_q && (dir_q == DIR_READ) && cred_ok && rd_room;
   assign mm_write_o  = act_q && (dir_q == DIR_WRITE) && cred_ok && wd_valid_i;
   assign wd_ready_o  = mm_write_o;
   assign fire        = mm_read_o || mm_write_o;

   assign mm_address_o    = {vfa_q, pf_q, vf_q, bar_q, aline_q, LSB'(0)};
   assign mm_burstcount_o = bsz_q;
   assign mm_writedata_o  = wd_data_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         act_q <= 1'b0;
         dir_q <= DIR_READ;
      end else if (acc) begin
         act_q <= 1'b1;
         dir_q <= req_write_i ? DIR_WRITE : DIR_READ;
      end else if (fire && left_q == step) begin
         act_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (acc) begin
         vfa_q   <= req_vf_active_i;
         pf_q    <= req_pf_i;
         vf_q    <= req_vf_i;
         bar_q   <= req_bar_i;
         sb_q    <= sb_n;
         eb_q    <= eb_n;
         fbe_q   <= req_fbe_i;
         lbe_q   <= req_lbe_i;
         tag_q   <= req_tag_i;
         line_q  <= sb_n[OFS_W-1:LSB];
         aline_q <= sb_n[OFS_W-1:LSB];
         left_q  <= tot_n;
         bsz_q   <= clip(tot_n);
         inb_q   <= clip(tot_n);
      end else if (fire) begin
         left_q <= left_n;
         line_q <= line_q + step[LINE_W-1:0];
         if (brk) begin
            aline_q <= line_q + step[LINE_W-1:0];
            bsz_q   <= clip(left_n);
            inb_q   <= clip(left_n);
         end else begin
            inb_q   <= inb_q - BC_W'(1);
         end
      end
   end

   bmm_be_gen #(.BE_W(BE_W), .POS_W(POS_W)) u_be (
      .line_i  ({1'b0, line_q}),
      .first_i (sb_q),
      .final_i (eb_q),
      .fbe_i   (fbe_q),
      .lbe_i   (lbe_q),
      .all_i   ((dir_q == DIR_READ) && (bsz_q != BC_W'(1))),
      .be_o    (mm_byteenable_o)
   );

   bmm_credit #(.ALLOW(ALLOW)) u_credit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wait_i (mm_waitrequest_i),
      .fire_i (fire),
      .ok_o   (cred_ok)
   );

   bmm_rsp_track #(.DATA_W(DATA_W), .TAG_W(TAG_W), .BC_W(BC_W), .DEPTH(RD_DEPTH)) u_rsp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (mm_read_o),
      .push_tag_i  (tag_q),
      .push_cnt_i  (bsz_q),
      .room_o      (rd_room),
      .rdv_i       (mm_readdatavalid_i),
      .rdata_i     (mm_readdata_i),
      .rsp_valid_o (rsp_valid_o),
      .rsp_data_o  (rsp_data_o),
      .rsp_tag_o   (rsp_tag_o),
      .rsp_last_o  (rsp_last_o)
   );
endmodule

// File: rtl/bmm_req_master_chk.sv
module bmm_req_master_chk #(
   parameter int unsigned ADDR_W = 39,
   parameter int unsigned BE_W   = 64,
   parameter int unsigned BC_W   = 4,
   parameter int unsigned ALLOW  = 16
)(
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] mm_address_o,
   input logic [BE_W-1:0]   mm_byteenable_o,
   input logic [BC_W-1:0]   mm_burstcount_o,
   input logic              mm_read_o,
   input logic              mm_write_o,
   input logic              mm_waitrequest_i,
   input logic              wd_valid_i,
   input logic              wd_ready_o,
   input logic              rsp_valid_o,
   input logic              rsp_last_o
);
   localparam int unsigned LSB = $clog2(BE_W);
   localparam int unsigned HW  = $clog2(ALLOW + 1) + 1;

   logic [HW-1:0]     hi_q;
   logic [BC_W-1:0]   wb_q, wbc_q;
   logic [ADDR_W-1:0] wa_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                   hi_q <= '0;
      else if (!mm_waitrequest_i)    hi_q <= '0;
      else if (mm_read_o || mm_write_o) hi_q <= hi_q + HW'(1);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         wb_q  <= '0;
         wbc_q <= '0;
         wa_q  <= '0;
      end else if (mm_write_o) begin
         if (wb_q == '0) begin
            wa_q  <= mm_address_o;
            wbc_q <= mm_burstcount_o;
         end
         if ((wb_q + BC_W'(1)) == ((wb_q == '0) ? mm_burstcount_o : wbc_q)) wb_q <= '0;
         else wb_q <= wb_q + BC_W'(1);
      end
   end

   AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mm_read_o || mm_write_o) |-> (mm_address_o[LSB-1:0] == '0)); // R2
   AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mm_read_o && mm_write_o)); // R8
   AST_MULTI_READ_ALL_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mm_read_o && mm_burstcount_o > BC_W'(1)) |-> (&mm_byteenable_o)); // R4
   AST_BURST_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mm_read_o || mm_write_o) |-> (mm_burstcount_o != '0)); // R5
   AST_ALLOWANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mm_read_o || mm_write_o) && mm_waitrequest_i) |-> (hi_q < HW'(ALLOW))); // R7
   AST_WR_BURST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mm_write_o && wb_q != '0) |-> (mm_address_o == wa_q && mm_burstcount_o == wbc_q)); // R6
   AST_WDATA_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mm_write_o |-> (wd_valid_i && wd_ready_o)); // R6
   AST_LAST_HAS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_last_o |-> rsp_valid_o); // R9
endmodule

bind bmm_req_master bmm_req_master_chk #(
   .ADDR_W(ADDR_W), .BE_W(BE_W), .BC_W(BC_W), .ALLOW(ALLOW)
) u_chk (
   .clk_i            (clk_i),
   .rst_ni           (rst_ni),
   .mm_address_o     (mm_address_o),
   .mm_byteenable_o  (mm_byteenable_o),
   .mm_burstcount_o  (mm_burstcount_o),
   .mm_read_o        (mm_read_o),
   .mm_write_o       (mm_write_o),
   .mm_waitrequest_i (mm_waitrequest_i),
   .wd_valid_i       (wd_valid_i),
   .wd_ready_o       (wd_ready_o),
   .rsp_valid_o      (rsp_valid_o),
   .rsp_last_o       (rsp_last_o)
);

// File: tb/bmm_req_master_tb_top.sv
module bmm_req_master_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic         rst_n;
   logic         req_valid, req_write, req_vfa;
   logic [1:0]   req_pf;
   logic [10:0]  req_vf;
   logic [2:0]   req_bar;
   logic [21:0]  req_ofs;
   logic [10:0]  req_len;
   logic [3:0]   req_fbe, req_lbe;
   logic [7:0]   req_tag;
   logic         wd_valid;
   logic [31:0]  wd_seq;
   logic [511:0] wd_data;
   logic [511:0] rdata;
   logic         rdv, wreq;

   logic         req_ready, wd_ready, mm_read, mm_write, rsp_valid, rsp_last;
   logic [38:0]  mm_addr;
   logic [63:0]  mm_be;
   logic [3:0]   mm_bc;
   logic [511:0] mm_wdata, rsp_data;
   logic [7:0]   rsp_tag;

   assign wd_data = {16{wd_seq}};

   bmm_req_master dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
      .req_vf_active_i(req_vfa), .req_pf_i(req_pf), .req_vf_i(req_vf),
      .req_bar_i(req_bar), .req_offset_i(req_ofs), .req_len_i(req_len),
      .req_fbe_i(req_fbe), .req_lbe_i(req_lbe), .req_tag_i(req_tag),
      .wd_valid_i(wd_valid), .wd_data_i(wd_data), .wd_ready_o(wd_ready),
      .mm_address_o(mm_addr), .mm_byteenable_o(mm_be), .mm_burstcount_o(mm_bc),
      .mm_read_o(mm_read), .mm_write_o(mm_write), .mm_writedata_o(mm_wdata),
      .mm_readdata_i(rdata), .mm_readdatavalid_i(rdv), .mm_waitrequest_i(wreq),
      .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_tag_o(rsp_tag),
      .rsp_last_o(rsp_last)
   );

   int n_chk = 0, n_bad = 0;
   int n_rd = 0, n_wr = 0, hi_fires = 0, overlap = 0;
   logic [38:0]  rd_a [64];
   logic [3:0]   rd_c [64];
   logic [63:0]  rd_b [64];
   logic [38:0]  wr_a [64];
   logic [3:0]   wr_c [64];
   logic [63:0]  wr_b [64];
   logic [31:0]  wr_d [64];

   always @(posedge clk) if (wd_valid && wd_ready) wd_seq <= wd_seq + 1;

   always @(negedge clk) if (rst_n) begin
      if (mm_read && mm_write) overlap++;
      if ((mm_read || mm_write) && wreq) hi_fires++;
      if (mm_read && n_rd < 64) begin
         rd_a[n_rd] = mm_addr; rd_c[n_rd] = mm_bc; rd_b[n_rd] = mm_be; n_rd++;
      end
      if (mm_write && n_wr < 64) begin
         wr_a[n_wr] = mm_addr; wr_c[n_wr] = mm_bc; wr_b[n_wr] = mm_be;
         wr_d[n_wr] = mm_wdata[31:0];
         if (mm_wdata != {16{mm_wdata[31:0]}}) wr_d[n_wr] = 32'hBAD0BAD0;
         n_wr++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic send(input bit w, input bit vfa, input logic [1:0] pf, input logic [10:0] vf,
                       input logic [2:0] bar, input logic [21:0] ofs, input logic [10:0] len,
                       input logic [3:0] fbe, input logic [3:0] lbe, input logic [7:0] tag);
      @(posedge clk); #1;
      req_valid = 1; req_write = w; req_vfa = vfa; req_pf = pf; req_vf = vf; req_bar = bar;
      req_ofs = ofs; req_len = len; req_fbe = fbe; req_lbe = lbe; req_tag = tag;
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (req_ready) break;
      end
   endtask

   task automatic respond(input int n, input logic [7:0] tag, input string req);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         rdv = 1; rdata = {16{32'hA000_0000 + 32'(i)}};
         @(negedge clk);
         chk(rsp_valid && rsp_tag == tag, req, {55'd0, rsp_valid, rsp_tag}, {55'd1, tag});
         chk(rsp_last == (i == n - 1), req, 64'(rsp_last), 64'(i == n - 1));
         chk(rsp_data == rdata, req, rsp_data[63:0], rdata[63:0]);
      end
      @(posedge clk); #1;
      rdv = 0;
   endtask

   // R10: idle after reset
   task automatic t_reset();
      @(negedge clk);
      chk(req_ready && !mm_read && !mm_write && !rsp_valid && !wd_ready, "R10 reset",
          {59'd0, req_ready, mm_read, mm_write, rsp_valid, wd_ready}, 64'h10);
   endtask

   // R1 R2 R3 R9: single-dword read, composite address, first-BE masking
   task automatic t_single_read();
      int r0 = n_rd;
      send(0, 1, 2'd2, 11'h5A5, 3'd3, 22'h001048, 11'd1, 4'b0110, 4'b0000, 8'h3C);
      wait_idle();
      chk(n_rd == r0 + 1, "R5 single read count", 64'(n_rd - r0), 64'd1);
      chk(rd_a[r0] == {1'b1, 2'd2, 11'h5A5, 3'd3, 22'h001040}, "R1 R2 address", 64'(rd_a[r0]),
          64'({1'b1, 2'd2, 11'h5A5, 3'd3, 22'h001040}));
      chk(rd_b[r0] == 64'h0000_0000_0000_0600, "R3 single read BE", rd_b[r0], 64'h600);
      chk(rd_c[r0] == 4'd1, "R5 single read count", 64'(rd_c[r0]), 64'd1);
      respond(1, 8'h3C, "R9 single beat return");
   endtask

   // R4 R9: three-line read ignores BE fields
   task automatic t_multi_read();
      int r0 = n_rd;
      send(0, 0, 2'd0, 11'd0, 3'd0, 22'h000010, 11'd40, 4'b0001, 4'b1000, 8'h51);
      wait_idle();
      chk(rd_c[r0] == 4'd3, "R5 multi read count", 64'(rd_c[r0]), 64'd3);
      chk(rd_b[r0] == '1, "R4 multi read BE", rd_b[r0], '1);
      chk(rd_a[r0] == 39'd0, "R2 multi read address", 64'(rd_a[r0]), 64'd0);
      respond(3, 8'h51, "R9 three beat return");
   endtask

   // R5: 16-line read splits 15 + 1
   task automatic t_split_read();
      int r0 = n_rd;
      send(0, 0, 2'd0, 11'd0, 3'd0, 22'h000000, 11'd256, 4'hF, 4'hF, 8'h77);
      wait_idle();
      chk(n_rd == r0 + 2, "R5 split burst count", 64'(n_rd - r0), 64'd2);
      chk(rd_c[r0] == 4'd15 && rd_c[r0+1] == 4'd1, "R5 split sizes",
          {rd_c[r0], rd_c[r0+1]}, {4'd15, 4'd1});
      chk(rd_a[r0+1] == 39'h3C0, "R5 split address step", 64'(rd_a[r0+1]), 64'h3C0);
      chk(rd_b[r0+1] == '1, "R3 tail single read BE", rd_b[r0+1], '1);
      respond(15, 8'h77, "R9 first split burst");
      respond(1, 8'h77, "R9 second split burst");
   endtask

   // R3 R6: two-beat write across a line with first/last BE
   task automatic t_write_edges();
      int w0 = n_wr;
      logic [31:0] s0 = wd_seq;
      send(1, 0, 2'd0, 11'd0, 3'd0, 22'h000038, 11'd4, 4'b1110, 4'b0011, 8'h12);
      wait_idle();
      chk(n_wr == w0 + 2, "R5 write beats", 64'(n_wr - w0), 64'd2);
      chk(wr_b[w0] == 64'hFE00_0000_0000_0000, "R3 write beat0 BE", wr_b[w0], 64'hFE00_0000_0000_0000);
      chk(wr_b[w0+1] == 64'h3F, "R3 write beat1 BE", wr_b[w0+1], 64'h3F);
      chk(wr_a[w0] == 39'd0 && wr_a[w0+1] == 39'd0 && wr_c[w0] == 4'd2 && wr_c[w0+1] == 4'd2,
          "R6 write burst held", {25'd0, wr_a[w0+1]}, 64'd0);
      chk(wr_d[w0] == s0 && wr_d[w0+1] == s0 + 1, "R6 write data order",
          {wr_d[w0], wr_d[w0+1]}, {s0, s0 + 32'd1});
   endtask

   // R7 R5 R10: 20-beat write under waitrequest
   task automatic t_allowance();
      int w0 = n_wr;
      @(posedge clk); #1; wreq = 1;
      repeat (3) @(posedge clk);
      #1; hi_fires = 0;
      send(1, 0, 2'd0, 11'd0, 3'd0, 22'h000000, 11'd320, 4'hF, 4'hF, 8'h05);
      repeat (30) @(negedge clk);
      chk(hi_fires == 16, "R7 transfers under waitrequest", 64'(hi_fires), 64'd16);
      chk(n_wr == w0 + 16, "R7 stall after allowance", 64'(n_wr - w0), 64'd16);
      chk(!req_ready, "R10 busy while issuing", 64'(req_ready), 64'd0);
      @(posedge clk); #1; wreq = 0;
      wait_idle();
      chk(n_wr == w0 + 20, "R7 resumes after release", 64'(n_wr - w0), 64'd20);
      chk(wr_a[w0+14] == 39'd0 && wr_c[w0+14] == 4'd15, "R5 first write burst",
          {25'd0, wr_a[w0+14]}, 64'd0);
      chk(wr_a[w0+15] == 39'h3C0 && wr_c[w0+15] == 4'd5, "R5 second write burst",
          {21'd0, wr_c[w0+15], wr_a[w0+15]}, {21'd0, 4'd5, 39'h3C0});
      chk(wr_b[w0+19] == '1, "R3 full line write BE", wr_b[w0+19], '1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog got=%h exp=%h", 64'd0, 64'd1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 0; req_valid = 0; req_write = 0; req_vfa = 0; req_pf = 0; req_vf = 0;
      req_bar = 0; req_ofs = 0; req_len = 0; req_fbe = 0; req_lbe = 0; req_tag = 0;
      wd_valid = 0; wd_seq = 32'h0000_1000; rdata = '0; rdv = 0; wreq = 0;
      repeat (4) @(posedge clk);
      #1; rst_n = 1; wd_valid = 1;
      t_reset();
      t_single_read();
      t_multi_read();
      t_split_read();
      t_write_edges();
      t_allowance();
      chk(overlap == 0, "R8 read/write exclusive", 64'(overlap), 64'd0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule